// File: doc/BRIEF.md
# Atomic Compare-and-Swap Memory Unit

This unit sits between one requester and a single-port synchronous memory and performs an indivisible compare-and-exchange. A request carries a word address, an operand size, a 64-bit compare value made of two 32-bit halves and a 64-bit replacement value made of two 32-bit halves. The unit reads the operand, compares it with the sized compare value, and writes the replacement only when the two are equal. The lock output stays high from the read to the conditional write, so no other master can reach the memory in between.

At completion a one-cycle done pulse comes with the equality flag and with the memory value that was read. A requester uses that value to reload its accumulator when the exchange fails. For 8, 16 and 32-bit operands the unit also updates five arithmetic flags as if the memory value had been subtracted from the compare value. The 64-bit mode uses both halves of the compare and replacement inputs and touches only the equality flag. A 64-bit request that names a register operand instead of memory produces an invalid-operation trap pulse and does nothing else.

Top module: `cas_unit`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` stays high from the following cycle until the cycle of `done` or `trap`, and `req_valid` is ignored while `busy` is high.
- R2: `req_size` encodes the operand width as 0=8, 1=16, 2=32, 3=64 bits. The compare value is the low bits of `cmp_lo`, or `{cmp_hi, cmp_lo}` for size 3.
- R3: In the cycle after acceptance the unit makes exactly one read at the captured address with `mem_lock` high. The memory returns data one cycle after the read, and the operand occupies the low bytes of the word.
- R4: On equality, `flag_zf` is 1 and exactly one write follows in the cycle after the read-data cycle. That write carries the low bits of `rep_lo`, or `{rep_hi, rep_lo}` for size 3, and has `mem_be` bit b set only for bytes b < 2^size. `mem_lock` stays high without a gap from the read through the write.
- R5: On inequality, `flag_zf` is 0, no write occurs, and the memory word is left unchanged.
- R6: `done_data` holds the operand read from memory, zero-extended above the operand width, on both the success and the failure paths.
- R7: For sizes 0 to 2 the flags follow the difference D = compare minus memory at the operand width. `flag_cf` is the unsigned borrow and `flag_sf` is the top bit of D. `flag_of` is the signed overflow, `flag_af` is the borrow out of bit 3, and `flag_pf` is 1 when the low 8 bits of D hold an even number of ones.
- R8: For size 3, `flag_zf` is the only flag updated. `flag_of`, `flag_sf`, `flag_af`, `flag_pf` and `flag_cf` keep their values.
- R9: `done` is a one-cycle pulse. It comes LAT_OK cycles after the accepting edge on success (default 7) and LAT_FAIL cycles after it on failure (default 10). Flags and `done_data` change only as `done` rises.
- R10: A size-3 request with `req_reg_form` high raises `trap` for one cycle, in the cycle after acceptance. It makes no memory access, gives no `done`, and leaves flags and `done_data` unchanged. For sizes 0 to 2, `req_reg_form` has no effect.
- R11: After reset, `busy`, `done`, `trap`, `mem_en`, `mem_we`, `mem_lock`, all flags and `done_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Word address of the operand |
| req_size | input | 2 | Operand width code |
| req_reg_form | input | 1 | Operand names a register instead of memory |
| cmp_lo | input | 32 | Compare value, low half |
| cmp_hi | input | 32 | Compare value, high half (size 3) |
| rep_lo | input | 32 | Replacement value, low half |
| rep_hi | input | 32 | Replacement value, high half (size 3) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| trap | output | 1 | Invalid-operation pulse |
| done_data | output | 64 | Operand read from memory |
| flag_zf | output | 1 | Equality flag |
| flag_of | output | 1 | Signed overflow of compare minus memory |
| flag_sf | output | 1 | Sign of the difference |
| flag_af | output | 1 | Borrow out of bit 3 |
| flag_pf | output | 1 | Even parity of the low difference byte |
| flag_cf | output | 1 | Unsigned borrow |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_lock | output | 1 | Memory held for this unit |
| mem_addr | output | AW | Memory word address |
| mem_be | output | 8 | Byte enables for the write |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid one cycle after a read |

## Verification
On every cycle the assertions check several properties. Any write happens under the lock, and a match is followed directly by a locked write. The done pulse reports the success path after exactly one write and the failure path after none. A trap cycle touches neither memory nor done, and a 64-bit completion leaves the five arithmetic flags stable. Only the bench's scenarios can show the exact success and failure latencies and the flag values for borrow, overflow and parity cases. They also show the byte-lane effect of each width on the stored word, and that a request arriving while busy is dropped.

// File: rtl/cas_pkg.sv
package cas_pkg;

  typedef enum logic [1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } op_size_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic brw;
  } cmp_flags_t;

  function automatic logic [63:0] width_mask(op_size_e s);
    case (s)
      SZ8:     return 64'h0000_0000_0000_00FF;
      SZ16:    return 64'h0000_0000_0000_FFFF;
      SZ32:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic logic top_bit(op_size_e s, logic [63:0] v);
    case (s)
      SZ8:     return v[7];
      SZ16:    return v[15];
      SZ32:    return v[31];
      default: return v[63];
    endcase
  endfunction

  // Flags of (a - m) at the operand width.
  function automatic cmp_flags_t sub_flags(op_size_e s, logic [63:0] a, logic [63:0] m);
    cmp_flags_t f;
    logic [63:0] am, mm, d;
    am    = a & width_mask(s);
    mm    = m & width_mask(s);
    d     = (am - mm) & width_mask(s);
    f.brw = am < mm;
    f.zro = (d == 64'd0);
    f.sgn = top_bit(s, d);
    f.ovf = (top_bit(s, am) != top_bit(s, mm)) && (top_bit(s, d) != top_bit(s, am));
    f.aux = am[3:0] < mm[3:0];
    f.par = ~^d[7:0];
    return f;
  endfunction

endpackage

// File: rtl/cas_lanes.sv
module cas_lanes
  import cas_pkg::*;
#(
  parameter int NB = 8
) (
  input  op_size_e          size,
  input  logic [NB*8-1:0]   rep,
  input  logic [NB*8-1:0]   rdata,
  output logic [NB*8-1:0]   wdata,
  output logic [NB*8-1:0]   rd_sized,
  output logic [NB-1:0]     be
);
  localparam int LW = $clog2(NB) + 1;

  logic [LW-1:0] lane_cnt;
  assign lane_cnt = LW'(1) << size;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic on;
    assign on                  = (LW'(b) < lane_cnt);
    assign be[b]               = on;
    assign wdata[8*b +: 8]     = on ? rep[8*b +: 8]   : 8'h00;
    assign rd_sized[8*b +: 8]  = on ? rdata[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/cas_compare.sv
module cas_compare
  import cas_pkg::*;
(
  input  op_size_e     size,
  input  logic [63:0]  acc,
  input  logic [63:0]  mem,
  output logic         match,
  output cmp_flags_t   flags
);
  assign match = ((acc ^ mem) & width_mask(size)) == 64'd0;
  assign flags = sub_flags(size, acc, mem);
endmodule

// File: rtl/cas_seq.sv
module cas_seq #(
  parameter int LAT_OK   = 7,
  parameter int LAT_FAIL = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bad,
  input  logic match,
  output logic busy,
  output logic rd_en,
  output logic wr_en,
  output logic lock,
  output logic cmp_phase,
  output logic fin,
  output logic done,
  output logic trap
);
  localparam int CW = $clog2(LAT_FAIL + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_CMP, S_WR, S_HOLD, S_DONE, S_TRAP
  } st_e;

  st_e           st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] tgt_q;

  assign fin = ((st_q == S_WR) || (st_q == S_HOLD)) && (cnt_q == tgt_q - CW'(1));

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (start) st_d = bad ? S_TRAP : S_RD;
      S_RD:   st_d = S_CMP;
      S_CMP:  st_d = match ? S_WR : S_HOLD;
      S_WR:   st_d = fin ? S_DONE : S_HOLD;
      S_HOLD: if (fin) st_d = S_DONE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      tgt_q <= CW'(LAT_FAIL);
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE) cnt_q <= CW'(1);
      else                cnt_q <= cnt_q + CW'(1);
      if (st_q == S_CMP) tgt_q <= match ? CW'(LAT_OK) : CW'(LAT_FAIL);
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign rd_en     = (st_q == S_RD);
  assign wr_en     = (st_q == S_WR);
  assign lock      = (st_q == S_RD) || (st_q == S_CMP) || (st_q == S_WR);
  assign cmp_phase = (st_q == S_CMP);
  assign done      = (st_q == S_DONE);
  assign trap      = (st_q == S_TRAP);

  // R1 R10: at most one of the phase outputs at a time
  p_phase_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en, done, trap}));

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: read follows acceptance of a legal request
  p_read_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !bad) |=> (rd_en && lock));
endmodule

// File: rtl/cas_unit.sv
module cas_unit
  import cas_pkg::*;
#(
  parameter int AW       = 4,
  parameter int LAT_OK   = 7,
  parameter int LAT_FAIL = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_reg_form,
  input  logic [31:0]   cmp_lo,
  input  logic [31:0]   cmp_hi,
  input  logic [31:0]   rep_lo,
  input  logic [31:0]   rep_hi,
  output logic          busy,
  output logic          done,
  output logic          trap,
  output logic [63:0]   done_data,
  output logic          flag_zf,
  output logic          flag_of,
  output logic          flag_sf,
  output logic          flag_af,
  output logic          flag_pf,
  output logic          flag_cf,
  output logic          mem_en,
  output logic          mem_we,
  output logic          mem_lock,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_be,
  output logic [63:0]   mem_wdata,
  input  logic [63:0]   mem_rdata
);
  localparam int DW = 64;
  localparam int HW = DW / 2;
  localparam int NB = DW / 8;

  logic          accept, bad_req, wide_req;
  logic [AW-1:0] addr_q;
  op_size_e      size_q;
  logic [DW-1:0] acc_q, rep_q;
  logic [DW-1:0] rd_sized;
  logic          cmp_match;
  cmp_flags_t    cmp_flg;
  logic          rd_en, wr_en, cmp_phase, fin;
  logic          zf_pend;
  cmp_flags_t    flg_pend;
  logic [DW-1:0] data_pend;

  // named events for the assertions
  logic ev_match, ev_mismatch, ev_wide_done;

  assign wide_req = (req_size == 2'd3);
  assign bad_req  = wide_req && req_reg_form;
  assign accept   = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= SZ8;
      acc_q  <= '0;
      rep_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      size_q <= op_size_e'(req_size);
      acc_q  <= {wide_req ? cmp_hi : {HW{1'b0}}, cmp_lo};
      rep_q  <= {wide_req ? rep_hi : {HW{1'b0}}, rep_lo};
    end
  end

  cas_lanes #(.NB(NB)) u_lanes (
    .size     (size_q),
    .rep      (rep_q),
    .rdata    (mem_rdata),
    .wdata    (mem_wdata),
    .rd_sized (rd_sized),
    .be       (mem_be)
  );

  cas_compare u_cmp (
    .size  (size_q),
    .acc   (acc_q),
    .mem   (rd_sized),
    .match (cmp_match),
    .flags (cmp_flg)
  );

  cas_seq #(.LAT_OK(LAT_OK), .LAT_FAIL(LAT_FAIL)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .bad       (bad_req),
    .match     (cmp_match),
    .busy      (busy),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .lock      (mem_lock),
    .cmp_phase (cmp_phase),
    .fin       (fin),
    .done      (done),
    .trap      (trap)
  );

  assign mem_en   = rd_en || wr_en;
  assign mem_we   = wr_en;
  assign mem_addr = addr_q;

  assign ev_match     = cmp_phase && cmp_match;
  assign ev_mismatch  = cmp_phase && !cmp_match;
  assign ev_wide_done = done && (size_q == SZ64);

  // capture the comparison while read data is on the port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zf_pend   <= 1'b0;
      flg_pend  <= '0;
      data_pend <= '0;
    end else if (cmp_phase) begin
      zf_pend   <= cmp_match;
      flg_pend  <= cmp_flg;
      data_pend <= rd_sized;
    end
  end

  // publish results as done rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_data <= '0;
      flag_zf   <= 1'b0;
      flag_of   <= 1'b0;
      flag_sf   <= 1'b0;
      flag_af   <= 1'b0;
      flag_pf   <= 1'b0;
      flag_cf   <= 1'b0;
    end else if (fin) begin
      done_data <= data_pend;
      flag_zf   <= zf_pend;
      if (size_q != SZ64) begin
        flag_of <= flg_pend.ovf;
        flag_sf <= flg_pend.sgn;
        flag_af <= flg_pend.aux;
        flag_pf <= flg_pend.par;
        flag_cf <= flg_pend.brw;
      end
    end
  end

  // checker-side write counter for the current operation
  logic [1:0] wr_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      wr_seen <= 2'd0;
    else if (accept)                 wr_seen <= 2'd0;
    else if (mem_we && wr_seen != 2'd3) wr_seen <= wr_seen + 2'd1;
  end

  // R4: writes only under lock
  p_write_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_lock);

  // R4: a match is followed directly by a locked write
  p_match_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_match |=> (mem_we && mem_lock));

  // R5: a mismatch is never followed by a write
  p_mismatch_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> !mem_we);

  // R4 R5: success reports one write, failure none
  p_done_zf_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_seen == (flag_zf ? 2'd1 : 2'd0)));

  // R10: trap cycle makes no access and no completion
  p_trap_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!mem_en && !done && !mem_lock));

  // R8: wide completion leaves arithmetic flags alone
  p_wide_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wide_done |-> $stable({flag_of, flag_sf, flag_af, flag_pf, flag_cf}));
endmodule

// File: tb/cas_unit_test.sv
module cas_unit_test;
  localparam int AW = 4;
  localparam int NW = 1 << AW;
  localparam int L_OK = 7;
  localparam int L_FAIL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_reg_form = 1'b0;
  logic [31:0]   cmp_lo = '0, cmp_hi = '0, rep_lo = '0, rep_hi = '0;
  logic          busy, done, trap;
  logic [63:0]   done_data;
  logic          flag_zf, flag_of, flag_sf, flag_af, flag_pf, flag_cf;
  logic          mem_en, mem_we, mem_lock;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_be;
  logic [63:0]   mem_wdata;
  logic [63:0]   mem_rdata;

  cas_unit #(.AW(AW), .LAT_OK(L_OK), .LAT_FAIL(L_FAIL)) uut (.*);

  function automatic logic [63:0] seed_word(int i);
    return 64'h0123_4567_89AB_CDEF ^ (64'(i) * 64'h1111_2222_3333_4445);
  endfunction

  // bench memory: synchronous read, byte-enabled write
  logic [63:0] ram [NW];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) ram[i] <= seed_word(i);
    end else if (mem_en) begin
      mem_rdata <= ram[mem_addr];
      if (mem_we)
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) ram[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  // reference state
  logic [63:0] ref_mem [NW];
  logic [63:0] ref_data;
  bit ref_zf, ref_of, ref_sf, ref_af, ref_pf, ref_cf;
  int n_chk = 0, n_fail = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    report();
  end

  task automatic chk_flags(string tag);
    chk({tag, " zf"}, 64'(flag_zf), 64'(ref_zf));
    chk({tag, " of sf af pf cf"},
        64'({flag_of, flag_sf, flag_af, flag_pf, flag_cf}),
        64'({ref_of, ref_sf, ref_af, ref_pf, ref_cf}));
    chk({tag, " data"}, done_data, ref_data);
  endtask

  // one complete request, reference computed from the requirements
  task automatic run_op(int sz, bit regf, int a, logic [31:0] clo, logic [31:0] chi,
                        logic [31:0] rlo, logic [31:0] rhi, bit poke_busy);
    int nbytes = 1 << sz;
    int top = 8 * nbytes - 1;
    logic [63:0] mask = (sz == 3) ? '1 : ((64'd1 << (8 * nbytes)) - 64'd1);
    logic [63:0] cv = (sz == 3) ? {chi, clo} : (64'(clo) & mask);
    logic [63:0] rv = (sz == 3) ? {rhi, rlo} : (64'(rlo) & mask);
    logic [63:0] mv = ref_mem[a] & mask;
    logic [63:0] d  = (cv - mv) & mask;
    bit ok = (cv == mv);
    bit is_trap = (sz == 3) && regf;
    int lat = ok ? L_OK : L_FAIL;
    req_valid = 1'b1; req_addr = AW'(a); req_size = 2'(sz); req_reg_form = regf;
    cmp_lo = clo; cmp_hi = chi; rep_lo = rlo; rep_hi = rhi;
    @(negedge clk);
    req_valid = 1'b0;
    if (is_trap) begin
      chk("R10 trap cycle {busy,trap,en,done}", 64'({busy, trap, mem_en, done}), 64'b1100);
      @(negedge clk);
      chk("R10 after trap {busy,trap}", 64'({busy, trap}), 64'b00);
      chk_flags("R10 unchanged");
      chk("R10 memory untouched", ram[a], ref_mem[a]);
      return;
    end
    for (int k = 1; k <= lat + 1; k++) begin
      bit e_lock = (k == 1) || (k == 2) || (ok && k == 3);
      bit e_en   = (k == 1) || (ok && k == 3);
      bit e_we   = ok && (k == 3);
      if (poke_busy && k == 2) begin
        req_valid = 1'b1; req_addr = AW'(a + 1); cmp_lo = ~clo;
      end
      if (poke_busy && k == 3) req_valid = 1'b0;
      chk($sformatf("R1 R3 R4 R9 cycle %0d {busy,lock,en,we,done}", k),
          64'({busy, mem_lock, mem_en, mem_we, done}),
          64'({k <= lat, e_lock, e_en, e_we, k == lat}));
      if (k == 1) chk("R3 read address", 64'(mem_addr), 64'(a));
      if (e_we) begin
        chk("R4 byte enables", 64'(mem_be), (64'd1 << nbytes) - 64'd1);
        chk("R4 write data", mem_wdata & mask, rv);
      end
      if (k == lat) begin
        ref_zf = ok;
        ref_data = mv;
        if (sz != 3) begin
          ref_cf = cv < mv;
          ref_sf = d[top];
          ref_of = (cv[top] != mv[top]) && (d[top] != cv[top]);
          ref_af = cv[3:0] < mv[3:0];
          ref_pf = ~^d[7:0];
        end
        if (ok) ref_mem[a] = (ref_mem[a] & ~mask) | rv;
        chk_flags(sz == 3 ? "R8 R6 wide result" : "R7 R6 narrow result");
      end
      @(negedge clk);
    end
    chk(ok ? "R4 memory after swap" : "R5 memory unchanged", ram[a], ref_mem[a]);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = seed_word(i);
    ref_data = '0;
    {ref_zf, ref_of, ref_sf, ref_af, ref_pf, ref_cf} = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset controls", 64'({busy, done, trap, mem_en, mem_we, mem_lock}), 64'd0);
    chk_flags("R11 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4 byte match
    run_op(0, 0, 1, 32'(ref_mem[1][7:0]) | 32'hABCD_0000, 32'h0, 32'h5A, 32'h0, 0);
    // R5 byte mismatch, acc above memory
    run_op(0, 0, 2, 32'(ref_mem[2][7:0] + 8'd1), 32'h0, 32'h11, 32'h0, 0);
    // R7 halfword borrow
    run_op(1, 0, 3, 32'(ref_mem[3][15:0] - 16'd1), 32'h0, 32'h2222, 32'h0, 0);
    // R1 word match with request while busy
    run_op(2, 0, 5, ref_mem[5][31:0], 32'hFFFF, 32'h7FFF_FFFF, 32'h0, 1);
    // R7 signed overflow: 0x80000000 - 0x7FFFFFFF
    run_op(2, 0, 5, 32'h8000_0000, 32'h0, 32'h0, 32'h0, 0);
    // R8 wide match, then wide mismatch keep narrow flags
    run_op(3, 0, 6, ref_mem[6][31:0], ref_mem[6][63:32], 32'hDEAD_BEEF, 32'hCAFE_F00D, 0);
    run_op(3, 0, 7, ref_mem[7][31:0], ~ref_mem[7][63:32], 32'h1, 32'h2, 0);
    // R10 wide register form traps; narrow register form executes
    run_op(3, 1, 8, 32'h0, 32'h0, 32'h3, 32'h4, 0);
    run_op(0, 1, 9, 32'(ref_mem[9][7:0]), 32'h0, 32'h77, 32'h0, 0);

    for (int n = 0; n < 40; n++) begin
      int a = int'($urandom_range(0, NW - 1));
      int s = int'($urandom_range(0, 3));
      bit hit = $urandom_range(0, 1) == 1;
      logic [31:0] lo = hit ? ref_mem[a][31:0]  : $urandom;
      logic [31:0] hi = hit ? ref_mem[a][63:32] : $urandom;
      run_op(s, $urandom_range(0, 3) == 0, a, lo, hi, $urandom, $urandom, n % 5 == 0);
    end
    report();
  end
endmodule